// File: doc/BRIEF.md
# Raster Timing Generator with Early Fetch Trigger

The block produces the raster timing for a video display interface from run-time geometry inputs: active size, front porch, sync width and back porch on each axis, plus a polarity bit per sync. It drives horizontal and vertical sync, a data-enable window, the pixel and line position, a one-cycle frame-start strobe and a one-cycle prefetch strobe. The prefetch strobe lets an upstream pixel fetcher start reading the next frame while the vertical front porch is still running. Its position comes from a worst-case fetch latency, given in lines, and from how much of that latency the sync and back porch already cover.

A frame starts on the first line of vertical sync. Every line starts with its active pixels. The geometry inputs are sampled only at frame start. The run enable also takes effect only at a frame boundary, so a frame is never torn. Two mode inputs change how the geometry is applied. One halves every horizontal value for one half of a split, dual-interface panel. The other forces both syncs active-high for a serial display link that cannot take active-low syncs. The pixel output passes the incoming pixel inside the active window, gives all ones while the fetcher reports underflow, and gives zero outside the window.

Top module: `raster_timing_gen`

## Requirements
- R1: A line lasts H = hact+hfp+hsw+hbp cycles. pix_cnt_o counts 0..H-1. The first hact cycles are active. Horizontal sync is active for hsw cycles starting at pix_cnt_o = hact+hfp.
- R2: A frame lasts V = vact+vfp+vsw+vbp lines. line_cnt_o counts 0..V-1 from frame start. Vertical sync is active on lines 0..vsw-1, so it starts in the frame's first cycle.
- R3: de_o is high exactly when pix_cnt_o < hact and vsw+vbp <= line_cnt_o < vsw+vbp+vact. That gives hact*vact cycles per frame, the first at cycle (vsw+vbp)*H.
- R4: Each sync has its own polarity input, where 1 means active-low. With dsi_mode_i = 1 both syncs are active-high. While stopped, each sync sits at its inactive level.
- R5: With split_mode_i = 1, hact, hfp, hsw and hbp are each shifted right by one bit before use.
- R6: Let S = vsw+vbp and W = fetch_lines_i. The prefetch line count n is 0 if S >= W. Otherwise n is vfp when vfp < W-S, and W-S in all other cases.
- R7: A frame counter is 0 in the frame-start cycle and counts up by one per cycle. prefetch_o is high for one cycle when the counter equals (V-n)*H+1. With n = 0 it never fires.
- R8: pix_o equals pix_i while de_o is high and underflow_i is low. It is all ones while de_o and underflow_i are both high, and zero while de_o is low.
- R9: After reset the block is stopped and all strobes and de_o are low. Raising en_i from stopped gives frame_start_o in the second cycle. Lowering en_i lets the current frame finish, and after that no further frame starts.
- R10: Geometry, polarity, mode and fetch-latency inputs are sampled only at frame start. Changing them during a frame does not alter that frame.
- R11: frame_start_o is a single-cycle pulse at the first cycle of a frame, and both position counters are zero in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| en_i | input | 1 | Run request, applied at frame boundaries |
| hact_i | input | 12 | Active pixels per line |
| hfp_i | input | 12 | Horizontal front porch, pixels |
| hsw_i | input | 12 | Horizontal sync width, pixels |
| hbp_i | input | 12 | Horizontal back porch, pixels |
| vact_i | input | 12 | Active lines per frame |
| vfp_i | input | 12 | Vertical front porch, lines |
| vsw_i | input | 12 | Vertical sync width, lines |
| vbp_i | input | 12 | Vertical back porch, lines |
| fetch_lines_i | input | 12 | Worst-case fetch latency in lines |
| hpol_i | input | 1 | Horizontal sync polarity, 1 = active-low |
| vpol_i | input | 1 | Vertical sync polarity, 1 = active-low |
| dsi_mode_i | input | 1 | Forces both syncs active-high |
| split_mode_i | input | 1 | Halves horizontal geometry |
| underflow_i | input | 1 | Fetcher underflow indication |
| pix_i | input | 24 | Incoming pixel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| frame_start_o | output | 1 | One-cycle frame-start strobe |
| prefetch_o | output | 1 | One-cycle fetch-start strobe |
| pix_cnt_o | output | 14 | Pixel position in line |
| line_cnt_o | output | 14 | Line position in frame |
| pix_o | output | 24 | Output pixel with fill colours |

## Verification
The bench runs all three prefetch-count cases: latency already covered by sync plus back porch, latency that fits in the front porch, and latency longer than the front porch. A design that clamps wrongly puts the strobe inside the active lines or fires it when none is due. Other runs check both polarity settings, the serial-link override and split halving; a wrong choice of active level shows up at once as a wrong sync count. A mid-frame geometry change catches a design that lets new settings leak into the running frame. A mid-frame disable catches a design that stops at once instead of finishing the frame. The bench also checks that restart gives frame start in the right cycle.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    parameter int unsigned IW = 12;
    parameter int unsigned CW = IW + 2;
    parameter int unsigned FW = 2 * CW;

    typedef struct packed {
        logic [CW-1:0] hact;
        logic [CW-1:0] hfp;
        logic [CW-1:0] hsw;
        logic [CW-1:0] htot;
        logic [CW-1:0] vact;
        logic [CW-1:0] vsw;
        logic [CW-1:0] vbp;
        logic [CW-1:0] vtot;
        logic          hpol;
        logic          vpol;
        logic          pf_en;
        logic [FW-1:0] pos;
    } work_t;
endpackage

// File: rtl/vtg_prefetch_pos.sv
module vtg_prefetch_pos
    import vtg_pkg::*;
(
    input  logic [CW-1:0] vfp_i,
    input  logic [CW-1:0] vsw_i,
    input  logic [CW-1:0] vbp_i,
    input  logic [CW-1:0] wc_i,
    input  logic [CW-1:0] htot_i,
    input  logic [CW-1:0] vtot_i,
    output logic          pf_en_o,
    output logic [FW-1:0] pos_o
);
    logic [CW-1:0] covered;
    logic [CW-1:0] need;
    logic [CW-1:0] lines;
    logic [FW-1:0] start_line;

    always_comb begin
        covered = vsw_i + vbp_i;
        need    = wc_i - covered;
        if (covered >= wc_i) begin
            lines = '0;
        end else if (vfp_i < need) begin
            lines = vfp_i;
        end else begin
            lines = need;
        end
        pf_en_o    = (lines != '0);
        start_line = FW'(vtot_i - lines);
        pos_o      = start_line * FW'(htot_i) + FW'(1);
    end
endmodule

// File: rtl/vtg_cfg_map.sv
module vtg_cfg_map
    import vtg_pkg::*;
(
    input  logic [IW-1:0] hact_i,
    input  logic [IW-1:0] hfp_i,
    input  logic [IW-1:0] hsw_i,
    input  logic [IW-1:0] hbp_i,
    input  logic [IW-1:0] vact_i,
    input  logic [IW-1:0] vfp_i,
    input  logic [IW-1:0] vsw_i,
    input  logic [IW-1:0] vbp_i,
    input  logic [IW-1:0] wc_i,
    input  logic          hpol_i,
    input  logic          vpol_i,
    input  logic          dsi_i,
    input  logic          split_i,
    output work_t         cfg_o
);
    localparam int unsigned NH = 4;

    logic [IW-1:0] h_raw [NH];
    logic [CW-1:0] h_eff [NH];
    logic [CW-1:0] vact, vfp, vsw, vbp, htot, vtot;
    logic          pf_en;
    logic [FW-1:0] pos;

    assign h_raw[0] = hact_i;
    assign h_raw[1] = hfp_i;
    assign h_raw[2] = hsw_i;
    assign h_raw[3] = hbp_i;

    // split panels: each half sees half the horizontal geometry
    for (genvar i = 0; i < NH; i++) begin : g_half
        assign h_eff[i] = split_i ? (CW'(h_raw[i]) >> 1) : CW'(h_raw[i]);
    end

    always_comb begin
        vact = CW'(vact_i);
        vfp  = CW'(vfp_i);
        vsw  = CW'(vsw_i);
        vbp  = CW'(vbp_i);
        htot = h_eff[0] + h_eff[1] + h_eff[2] + h_eff[3];
        vtot = vact + vfp + vsw + vbp;
    end

    vtg_prefetch_pos u_pf (
        .vfp_i   (vfp),
        .vsw_i   (vsw),
        .vbp_i   (vbp),
        .wc_i    (CW'(wc_i)),
        .htot_i  (htot),
        .vtot_i  (vtot),
        .pf_en_o (pf_en),
        .pos_o   (pos)
    );

    always_comb begin
        cfg_o.hact  = h_eff[0];
        cfg_o.hfp   = h_eff[1];
        cfg_o.hsw   = h_eff[2];
        cfg_o.htot  = htot;
        cfg_o.vact  = vact;
        cfg_o.vsw   = vsw;
        cfg_o.vbp   = vbp;
        cfg_o.vtot  = vtot;
        cfg_o.hpol  = hpol_i & ~dsi_i;
        cfg_o.vpol  = vpol_i & ~dsi_i;
        cfg_o.pf_en = pf_en;
        cfg_o.pos   = pos;
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import vtg_pkg::*;
#(
    parameter int unsigned PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [IW-1:0]    hact_i,
    input  logic [IW-1:0]    hfp_i,
    input  logic [IW-1:0]    hsw_i,
    input  logic [IW-1:0]    hbp_i,
    input  logic [IW-1:0]    vact_i,
    input  logic [IW-1:0]    vfp_i,
    input  logic [IW-1:0]    vsw_i,
    input  logic [IW-1:0]    vbp_i,
    input  logic [IW-1:0]    fetch_lines_i,
    input  logic             hpol_i,
    input  logic             vpol_i,
    input  logic             dsi_mode_i,
    input  logic             split_mode_i,
    input  logic             underflow_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             frame_start_o,
    output logic             prefetch_o,
    output logic [CW-1:0]    pix_cnt_o,
    output logic [CW-1:0]    line_cnt_o,
    output logic [PIX_W-1:0] pix_o
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] h;
        logic [CW-1:0] v;
        logic [FW-1:0] fcnt;
        work_t         work;
    } st_t;

    work_t cfg_nxt;
    st_t   st_d, st_q;
    logic  last_pix_d, last_line_d, frame_end_d;
    logic  hs_act_d, vs_act_d, de_act_d;
    logic [CW-1:0] hs_beg_d, act_beg_d;

    vtg_cfg_map u_map (
        .hact_i  (hact_i),
        .hfp_i   (hfp_i),
        .hsw_i   (hsw_i),
        .hbp_i   (hbp_i),
        .vact_i  (vact_i),
        .vfp_i   (vfp_i),
        .vsw_i   (vsw_i),
        .vbp_i   (vbp_i),
        .wc_i    (fetch_lines_i),
        .hpol_i  (hpol_i),
        .vpol_i  (vpol_i),
        .dsi_i   (dsi_mode_i),
        .split_i (split_mode_i),
        .cfg_o   (cfg_nxt)
    );

    // next-state: counters advance while running; boundary reloads settings
    always_comb begin
        st_d        = st_q;
        last_pix_d  = (st_q.h == st_q.work.htot - CW'(1));
        last_line_d = (st_q.v == st_q.work.vtot - CW'(1));
        frame_end_d = st_q.run && last_pix_d && last_line_d;
        if (!st_q.run) begin
            st_d.h    = '0;
            st_d.v    = '0;
            st_d.fcnt = '0;
            if (en_i) begin
                st_d.run  = 1'b1;
                st_d.work = cfg_nxt;
            end
        end else if (frame_end_d) begin
            st_d.run  = en_i;
            st_d.h    = '0;
            st_d.v    = '0;
            st_d.fcnt = '0;
            st_d.work = cfg_nxt;
        end else begin
            st_d.fcnt = st_q.fcnt + FW'(1);
            if (last_pix_d) begin
                st_d.h = '0;
                st_d.v = st_q.v + CW'(1);
            end else begin
                st_d.h = st_q.h + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // output decode from the registered position
    always_comb begin
        hs_beg_d  = st_q.work.hact + st_q.work.hfp;
        act_beg_d = st_q.work.vsw + st_q.work.vbp;
        hs_act_d  = st_q.run && (st_q.h >= hs_beg_d) && (st_q.h < hs_beg_d + st_q.work.hsw);
        vs_act_d  = st_q.run && (st_q.v < st_q.work.vsw);
        de_act_d  = st_q.run && (st_q.h < st_q.work.hact) && (st_q.v >= act_beg_d)
                    && (st_q.v < act_beg_d + st_q.work.vact);
        hsync_o       = hs_act_d ^ st_q.work.hpol;
        vsync_o       = vs_act_d ^ st_q.work.vpol;
        de_o          = de_act_d;
        frame_start_o = st_q.run && (st_q.h == '0) && (st_q.v == '0);
        prefetch_o    = st_q.run && st_q.work.pf_en && (st_q.fcnt == st_q.work.pos);
        pix_cnt_o     = st_q.h;
        line_cnt_o    = st_q.v;
        if (!de_act_d) begin
            pix_o = '0;
        end else if (underflow_i) begin
            pix_o = '1;
        end else begin
            pix_o = pix_i;
        end
    end

    // R9: a running raster only stops at the last pixel of a frame
    assert_stop_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> $past(frame_end_d));

    // R10: settings stay frozen inside a frame
    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !frame_end_d) |=> $stable(st_q.work));

    // R7: frame counter origin coincides with the frame-start strobe
    assert_fcnt_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> (st_q.fcnt == '0));

    // R1: line wraps after its last pixel
    assert_line_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && last_pix_d) |=> (st_q.h == '0));

    // R11: frame and prefetch strobes never coincide
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_start_o, prefetch_o}));
endmodule

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
    localparam int PW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0;
    logic [11:0] hact_i, hfp_i, hsw_i, hbp_i, vact_i, vfp_i, vsw_i, vbp_i, fetch_lines_i;
    logic hpol_i, vpol_i, dsi_mode_i, split_mode_i, underflow_i;
    logic [PW-1:0] pix_i;
    logic hsync_o, vsync_o, de_o, frame_start_o, prefetch_o;
    logic [13:0] pix_cnt_o, line_cnt_o;
    logic [PW-1:0] pix_o;

    always #2 clk = ~clk;

    raster_timing_gen #(.PIX_W(PW)) u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .hact_i(hact_i), .hfp_i(hfp_i), .hsw_i(hsw_i), .hbp_i(hbp_i),
        .vact_i(vact_i), .vfp_i(vfp_i), .vsw_i(vsw_i), .vbp_i(vbp_i),
        .fetch_lines_i(fetch_lines_i), .hpol_i(hpol_i), .vpol_i(vpol_i),
        .dsi_mode_i(dsi_mode_i), .split_mode_i(split_mode_i),
        .underflow_i(underflow_i), .pix_i(pix_i),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .frame_start_o(frame_start_o), .prefetch_o(prefetch_o),
        .pix_cnt_o(pix_cnt_o), .line_cnt_o(line_cnt_o), .pix_o(pix_o)
    );

    typedef struct {
        int    flen, hs_first, hs_n, vs_first, vs_n, de_first, de_n, pf_at, pf_n;
        bit    hpol, vpol;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int total = 0;
    int bad = 0;
    bit armed = 0;
    int off, m_hs_f, m_hs_n, m_vs_f, m_vs_n, m_de_f, m_de_n, m_pf_at, m_pf_n, m_pix_bad;

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // expected frame figures derived from the requirement formulas
    function automatic exp_t mk(input string tag);
        exp_t e;
        int ha, hf, hs, hb, ht, vt, s, need, n;
        ha = split_mode_i ? hact_i / 2 : hact_i;
        hf = split_mode_i ? hfp_i / 2 : hfp_i;
        hs = split_mode_i ? hsw_i / 2 : hsw_i;
        hb = split_mode_i ? hbp_i / 2 : hbp_i;
        ht = ha + hf + hs + hb;
        vt = vact_i + vfp_i + vsw_i + vbp_i;
        s  = vsw_i + vbp_i;
        if (s >= int'(fetch_lines_i)) n = 0;
        else begin
            need = fetch_lines_i - s;
            n = (vfp_i < need) ? int'(vfp_i) : need;
        end
        e.flen = vt * ht;
        e.hs_first = ha + hf;
        e.hs_n = vt * hs;
        e.vs_first = 0;
        e.vs_n = vsw_i * ht;
        e.de_first = s * ht;
        e.de_n = ha * vact_i;
        e.pf_at = (n > 0) ? (vt - n) * ht + 1 : -1;
        e.pf_n = (n > 0) ? 1 : 0;
        e.hpol = hpol_i & ~dsi_mode_i;
        e.vpol = vpol_i & ~dsi_mode_i;
        e.tag = tag;
        return e;
    endfunction

    task automatic close_frame();
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " R1 R2 frame length"}, off, e.flen);
        chk({e.tag, " R1 hsync start"}, m_hs_f, e.hs_first);
        chk({e.tag, " R1 R4 hsync active cycles"}, m_hs_n, e.hs_n);
        chk({e.tag, " R2 vsync start"}, m_vs_f, e.vs_first);
        chk({e.tag, " R2 R4 vsync active cycles"}, m_vs_n, e.vs_n);
        chk({e.tag, " R3 de first"}, m_de_f, e.de_first);
        chk({e.tag, " R3 de cycles"}, m_de_n, e.de_n);
        chk({e.tag, " R6 R7 prefetch count"}, m_pf_n, e.pf_n);
        chk({e.tag, " R7 prefetch position"}, m_pf_at, e.pf_at);
        chk({e.tag, " R8 pixel mismatches"}, m_pix_bad, 0);
    endtask

    // monitor: measures each armed frame, compares against the queue head
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_start_o) begin
                if (armed) close_frame();
                armed = (exp_q.size() > 0);
                if (armed) begin
                    cur = exp_q[0];
                    chk({cur.tag, " R11 counters zero at frame start"},
                        {pix_cnt_o, line_cnt_o}, 0);
                end
                off = 0; m_hs_f = -1; m_hs_n = 0; m_vs_f = -1; m_vs_n = 0;
                m_de_f = -1; m_de_n = 0; m_pf_at = -1; m_pf_n = 0; m_pix_bad = 0;
            end
            if (armed) begin
                if (hsync_o != cur.hpol) begin
                    m_hs_n++;
                    if (m_hs_f < 0) m_hs_f = off;
                end
                if (vsync_o != cur.vpol) begin
                    m_vs_n++;
                    if (m_vs_f < 0) m_vs_f = off;
                end
                if (de_o) begin
                    m_de_n++;
                    if (m_de_f < 0) m_de_f = off;
                end
                if (prefetch_o) begin
                    m_pf_n++;
                    m_pf_at = off;
                end
                if (pix_o != (de_o ? (underflow_i ? {PW{1'b1}} : pix_i) : {PW{1'b0}}))
                    m_pix_bad++;
                off++;
            end
        end
    end

    // pixel and underflow stimulus, driven away from the sampling edge
    initial begin
        pix_i = '0;
        underflow_i = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            pix_i = PW'($urandom);
            underflow_i = ($urandom % 5) == 0;
        end
    end

    task automatic wait_fs();
        do @(negedge clk); while (!frame_start_o);
    endtask

    task automatic run_case(input string tag);
        wait_fs();
        wait_fs();
        @(posedge clk);
        #1;
        exp_q.push_back(mk(tag));
        wait (exp_q.size() == 0);
    endtask

    task automatic set_base();
        @(posedge clk);
        #1;
        hact_i = 8; hfp_i = 2; hsw_i = 3; hbp_i = 2;
        vact_i = 6; vfp_i = 4; vsw_i = 2; vbp_i = 1;
        fetch_lines_i = 5;
        hpol_i = 0; vpol_i = 0; dsi_mode_i = 0; split_mode_i = 0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R9 act=%0d exp=%0d", 0, 1);
        summary();
    end

    initial begin
        int cnt_de, cnt_fs, cnt_pf;
        hact_i = 8; hfp_i = 2; hsw_i = 3; hbp_i = 2;
        vact_i = 6; vfp_i = 4; vsw_i = 2; vbp_i = 1;
        fetch_lines_i = 5;
        hpol_i = 0; vpol_i = 0; dsi_mode_i = 0; split_mode_i = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset de", de_o, 0);
        chk("R9 reset strobes", {frame_start_o, prefetch_o}, 0);
        chk("R4 reset sync idle", {hsync_o, vsync_o}, 0);
        chk("R8 reset pixel", pix_o, 0);

        // R9: start from stopped gives frame start in the second cycle
        @(posedge clk);
        #1 en_i = 1'b1;
        @(negedge clk);
        chk("R9 no frame start in first cycle", frame_start_o, 0);
        @(negedge clk);
        chk("R9 frame start in second cycle", frame_start_o, 1);
        @(negedge clk);
        chk("R11 frame start one cycle", frame_start_o, 0);

        run_case("fit R6");
        @(posedge clk); #1 fetch_lines_i = 3;
        run_case("covered R6 R7");
        @(posedge clk); #1 fetch_lines_i = 10;
        run_case("clamp R6 R7");

        set_base();
        hpol_i = 1; vpol_i = 1;
        run_case("active-low R4");
        @(posedge clk); #1 dsi_mode_i = 1;
        run_case("serial override R4");

        set_base();
        split_mode_i = 1; hact_i = 16; hfp_i = 4; hsw_i = 6; hbp_i = 5;
        run_case("split R5");

        // R10: mid-frame change must not touch the measured frame
        set_base();
        wait_fs();
        wait_fs();
        @(posedge clk);
        #1 exp_q.push_back(mk("frozen R10"));
        wait_fs();
        repeat (20) @(posedge clk);
        #1 hact_i = 5; vact_i = 4; hsw_i = 1; fetch_lines_i = 9;
        wait (exp_q.size() == 0);

        // R9: disable mid-frame, the frame completes then stops
        set_base();
        wait_fs();
        wait_fs();
        repeat (10) @(posedge clk);
        #1 en_i = 1'b0;
        cnt_de = 0; cnt_fs = 0; cnt_pf = 0;
        for (int i = 0; i < 2 * 195; i++) begin
            @(negedge clk);
            cnt_de += de_o;
            cnt_fs += frame_start_o;
            cnt_pf += prefetch_o;
        end
        chk("R9 frame completes after disable", cnt_de, 48);
        chk("R9 no frame after disable", cnt_fs, 0);
        chk("R9 R7 prefetch in last frame", cnt_pf, 1);
        chk("R4 R9 syncs idle when stopped", {hsync_o, vsync_o}, 0);

        @(posedge clk);
        #1 en_i = 1'b1;
        @(negedge clk);
        chk("R9 restart first cycle", frame_start_o, 0);
        @(negedge clk);
        chk("R9 restart frame start", frame_start_o, 1);
        run_case("restart R9");

        summary();
    end
endmodule